// File: doc/BRIEF.md
# Stream Table Entry Address Generator

This block turns a stream ID into the memory address of that stream's 64-byte table entry. It reads its settings from two inputs: a raw table base and a table configuration word. The configuration word gives the table size exponent, the split point between the level-1 and level-2 indices, and the table format. A requester hands over one lookup at a time on a valid/ready pair. When the lookup ends, the block emits a one-cycle done pulse that carries either the entry address or a fault code.

In linear format the entry address follows directly from the aligned base and the stream ID. In two-level format the block first issues a read of the 8-byte level-1 descriptor. It then waits for the descriptor on a simple response port. It checks the descriptor's span and adds the level-2 offset to the descriptor's pointer. A stream ID beyond the configured or implemented range is rejected before any memory access takes place. A failed descriptor read produces a fault record that holds the descriptor address.

Top module: `ste_addr_gen`

## Requirements
- R1: After reset, `done` and `mem_req_valid` are low and `req_ready` is high.
- R2: A stream ID is rejected when it is greater than or equal to 2^min(L, IMPL_SID_BITS), where L is `tbl_cfg[5:0]`. A rejected lookup gives `done` one cycle after acceptance with `done_fault` = 1 (bad stream ID), `done_addr` = 0, and no memory request.
- R3: The raw base is first masked so that only address bits 51 down to 6 survive.
- R4: In linear format, the masked base has its low (L + 5) bits cleared. `done` rises one cycle after acceptance with `done_fault` = 0 and `done_addr` = base + sid × 64.
- R5: In two-level format, the masked base has its low max(5, L − S + 2) bits cleared, where S is `tbl_cfg[10:6]`. L is used here without the implemented-size limit.
- R6: In two-level format, `mem_req_valid` pulses for exactly one cycle, one cycle after acceptance. Its address is base + (sid >> S) × 8.
- R7: The descriptor holds its span in bits 4:0 and its level-2 pointer in bits 51:6. On a good response, `done` rises one cycle later with `done_fault` = 0 and `done_addr` = pointer + (sid & (2^S − 1)) × 64.
- R8: A descriptor span of zero, or a level-2 index not below 2^(span − 1), ends the lookup with `done_fault` = 2 (bad descriptor).
- R9: A response with `mem_rsp_err` high ends the lookup with `done_fault` = 3 (fetch fault). The descriptor address is returned with its low 32 bits on `flt_word6` and its high 32 bits on `flt_word7`.
- R10: While a two-level lookup waits for its response, `req_ready` is low and `req_valid` is ignored: no extra `done` is produced and the pending result is unchanged.
- R11: The format field is `tbl_cfg[17:16]`. The value 1 selects two-level format, and every other value selects linear format.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request |
| req_ready | output | 1 | High when idle; a request is taken when both are high |
| req_sid | input | SID_W | Stream ID to look up |
| tbl_base | input | 64 | Raw stream table base |
| tbl_cfg | input | 32 | Table configuration: [5:0] size exponent, [10:6] split, [17:16] format |
| mem_req_valid | output | 1 | One-cycle level-1 descriptor read request |
| mem_req_addr | output | 64 | Level-1 descriptor address |
| mem_rsp_valid | input | 1 | Descriptor response |
| mem_rsp_err | input | 1 | Descriptor read failed |
| mem_rsp_data | input | 64 | Descriptor: [4:0] span, [51:6] level-2 pointer |
| done | output | 1 | One-cycle completion pulse |
| done_fault | output | 2 | 0 none, 1 bad stream ID, 2 bad descriptor, 3 fetch fault |
| done_addr | output | 64 | Entry address when no fault |
| flt_word6 | output | 32 | Fetch fault record: descriptor address bits 31:0 |
| flt_word7 | output | 32 | Fetch fault record: descriptor address bits 63:32 |

## Verification
Linear lookups use bases that are full of ones, so a wrong address mask or a wrong alignment width shows up in the result. Stream IDs are placed just below and just above the range limit. This includes a size exponent above the implemented limit, which tells the configured bound apart from the implemented one, and a size exponent of zero. Two-level lookups vary the size exponent and the split. Some of these push the alignment onto its minimum of 5 bits and others move it above 5, and the descriptors carry spans that sit exactly at the level-2 bound, just over it, and at zero. A read error checks which fault word each half of the address lands in. A request raised while a lookup is pending, and a format value of 2, show that both are handled as the requirements state.

// File: rtl/ste_pkg.sv
package ste_pkg;
  typedef enum logic [1:0] {
    FLT_NONE     = 2'd0,
    FLT_BAD_SID  = 2'd1,
    FLT_BAD_DESC = 2'd2,
    FLT_FETCH    = 2'd3
  } ste_fault_e;

  localparam logic [63:0] ADDR_KEEP = 64'h000F_FFFF_FFFF_FFC0;

  // Mask that clears the low n bits (all bits when n >= 64).
  function automatic logic [63:0] clr_low(input logic [7:0] n);
    if (n >= 8'd64) return '0;
    return ~((64'd1 << n) - 64'd1);
  endfunction
endpackage

// File: rtl/ste_range_chk.sv
module ste_range_chk #(
  parameter int SID_W         = 16,
  parameter int IMPL_SID_BITS = 16
) (
  input  logic [SID_W-1:0] sid,
  input  logic [5:0]       log2size,
  output logic             out_of_range
);
  localparam logic [6:0] IMPL_LIM = 7'(IMPL_SID_BITS);
  localparam logic [6:0] SID_LIM  = 7'(SID_W);

  logic [6:0] lim;

  always_comb begin
    lim = ({1'b0, log2size} < IMPL_LIM) ? {1'b0, log2size} : IMPL_LIM;
    if (lim >= SID_LIM) out_of_range = 1'b0;
    else                out_of_range = ((sid >> lim) != '0);
  end
endmodule

// File: rtl/ste_base_align.sv
module ste_base_align
  import ste_pkg::*;
(
  input  logic [63:0] raw_base,
  input  logic [5:0]  log2size,
  input  logic [4:0]  split,
  input  logic        two_lvl,
  output logic [63:0] base
);
  logic signed [8:0] two_sh;
  logic [7:0]        sh;

  always_comb begin
    two_sh = $signed({3'b000, log2size}) - $signed({4'b0000, split}) + 9'sd2;
    if (two_lvl) sh = (two_sh < 9'sd5) ? 8'd5 : two_sh[7:0];
    else         sh = {2'b00, log2size} + 8'd5;
    base = raw_base & ADDR_KEEP & clr_low(sh);
  end
endmodule

// File: rtl/ste_index_split.sv
module ste_index_split #(
  parameter int SID_W = 16
) (
  input  logic [SID_W-1:0] sid,
  input  logic [4:0]       split,
  output logic [SID_W-1:0] l1_idx,
  output logic [SID_W-1:0] l2_idx
);
  logic [31:0] low_mask;

  always_comb begin
    low_mask = (32'd1 << split) - 32'd1;
    l1_idx   = sid >> split;
    l2_idx   = sid & low_mask[SID_W-1:0];
  end
endmodule

// File: rtl/ste_addr_gen.sv
module ste_addr_gen
  import ste_pkg::*;
#(
  parameter int SID_W         = 16,
  parameter int IMPL_SID_BITS = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [SID_W-1:0] req_sid,
  input  logic [63:0]      tbl_base,
  input  logic [31:0]      tbl_cfg,
  output logic             mem_req_valid,
  output logic [63:0]      mem_req_addr,
  input  logic             mem_rsp_valid,
  input  logic             mem_rsp_err,
  input  logic [63:0]      mem_rsp_data,
  output logic             done,
  output logic [1:0]       done_fault,
  output logic [63:0]      done_addr,
  output logic [31:0]      flt_word6,
  output logic [31:0]      flt_word7
);
  typedef enum logic {ST_IDLE, ST_WAIT} st_e;

  logic [5:0]       log2size;
  logic [4:0]       split;
  logic             two_lvl, oor, accept, span_bad;
  logic [63:0]      base, lin_addr, l1_addr, l2_ptr, fin_addr;
  logic [SID_W-1:0] l1_idx, l2_idx;
  logic [4:0]       span;

  st_e              state_q, state_d;
  logic             done_q, done_d, mreq_q, mreq_d;
  ste_fault_e       fault_q, fault_d;
  logic [63:0]      daddr_q, daddr_d, maddr_q, maddr_d;
  logic [31:0]      w6_q, w6_d, w7_q, w7_d;
  logic [SID_W-1:0] l2_q, l2_d;

  logic unused_cfg_bits;
  assign unused_cfg_bits = ^{tbl_cfg[31:18], tbl_cfg[15:11], mem_rsp_data[63:52], mem_rsp_data[5]};

  assign log2size = tbl_cfg[5:0];
  assign split    = tbl_cfg[10:6];
  assign two_lvl  = (tbl_cfg[17:16] == 2'd1);

  ste_range_chk #(.SID_W(SID_W), .IMPL_SID_BITS(IMPL_SID_BITS)) u_range (
    .sid(req_sid), .log2size(log2size), .out_of_range(oor));

  ste_base_align u_align (
    .raw_base(tbl_base), .log2size(log2size), .split(split),
    .two_lvl(two_lvl), .base(base));

  ste_index_split #(.SID_W(SID_W)) u_split (
    .sid(req_sid), .split(split), .l1_idx(l1_idx), .l2_idx(l2_idx));

  assign accept   = req_valid && (state_q == ST_IDLE);
  assign lin_addr = base + (64'(req_sid) << 6);
  assign l1_addr  = base + (64'(l1_idx) << 3);
  assign span     = mem_rsp_data[4:0];
  assign l2_ptr   = mem_rsp_data & ADDR_KEEP;
  assign fin_addr = l2_ptr + (64'(l2_q) << 6);
  assign span_bad = (span == 5'd0) || ((l2_q >> (span - 5'd1)) != '0);

  always_comb begin
    state_d = state_q;
    done_d  = 1'b0;
    fault_d = FLT_NONE;
    daddr_d = '0;
    w6_d    = '0;
    w7_d    = '0;
    mreq_d  = 1'b0;
    maddr_d = maddr_q;
    l2_d    = l2_q;
    case (state_q)
      ST_IDLE: begin
        if (accept) begin
          if (oor) begin
            done_d  = 1'b1;
            fault_d = FLT_BAD_SID;
          end else if (two_lvl) begin
            mreq_d  = 1'b1;
            maddr_d = l1_addr;
            l2_d    = l2_idx;
            state_d = ST_WAIT;
          end else begin
            done_d  = 1'b1;
            daddr_d = lin_addr;
          end
        end
      end
      default: begin
        if (mem_rsp_valid) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
          if (mem_rsp_err) begin
            fault_d = FLT_FETCH;
            w6_d    = maddr_q[31:0];
            w7_d    = maddr_q[63:32];
          end else if (span_bad) begin
            fault_d = FLT_BAD_DESC;
          end else begin
            daddr_d = fin_addr;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
      fault_q <= FLT_NONE;
      daddr_q <= '0;
      w6_q    <= '0;
      w7_q    <= '0;
      mreq_q  <= 1'b0;
      maddr_q <= '0;
      l2_q    <= '0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      fault_q <= fault_d;
      daddr_q <= daddr_d;
      w6_q    <= w6_d;
      w7_q    <= w7_d;
      mreq_q  <= mreq_d;
      maddr_q <= maddr_d;
      l2_q    <= l2_d;
    end
  end

  assign req_ready     = (state_q == ST_IDLE);
  assign mem_req_valid = mreq_q;
  assign mem_req_addr  = maddr_q;
  assign done          = done_q;
  assign done_fault    = fault_q;
  assign done_addr     = daddr_q;
  assign flt_word6     = w6_q;
  assign flt_word7     = w7_q;

  // R2
  bad_sid_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept && oor |=> done && done_fault == 2'd1 && !mem_req_valid);
  // R6
  mreq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |=> !mem_req_valid);
  // R6
  mreq_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> mem_req_addr[2:0] == 3'd0);
  // R4
  entry_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && done_fault == 2'd0 |-> done_addr[5:0] == 6'd0);
  // R9
  fetch_record_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready && mem_rsp_valid && mem_rsp_err |=>
      done && done_fault == 2'd3 && {flt_word7, flt_word6} == $past(mem_req_addr));
  // R10
  busy_no_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready && !mem_rsp_valid |=> !done);
endmodule

// File: tb/ste_addr_gen_bench.sv
module ste_addr_gen_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [63:0] KEEP = 64'h000F_FFFF_FFFF_FFC0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready;
  logic [15:0] req_sid = '0;
  logic [63:0] tbl_base = '0;
  logic [31:0] tbl_cfg = '0;
  logic mem_req_valid;
  logic [63:0] mem_req_addr;
  logic mem_rsp_valid = 1'b0, mem_rsp_err = 1'b0;
  logic [63:0] mem_rsp_data = '0;
  logic done;
  logic [1:0] done_fault;
  logic [63:0] done_addr;
  logic [31:0] flt_word6, flt_word7;

  int checks = 0, errors = 0;

  typedef struct packed {
    logic [63:0] addr;
    logic [1:0]  fault;
    logic [31:0] w6;
    logic [31:0] w7;
  } exp_t;
  exp_t  expq[$];
  string tagq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  ste_addr_gen u_ste_addr_gen (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_sid(req_sid), .tbl_base(tbl_base), .tbl_cfg(tbl_cfg),
    .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_err(mem_rsp_err),
    .mem_rsp_data(mem_rsp_data), .done(done), .done_fault(done_fault),
    .done_addr(done_addr), .flt_word6(flt_word6), .flt_word7(flt_word7));

  task automatic check(input string tag, input logic ok, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] keep_above(input logic [63:0] v, input int n);
    if (n >= 64) return '0;
    return v & ~((64'd1 << n) - 64'd1);
  endfunction

  // Monitor: pops the scoreboard on each done pulse.
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (expq.size() == 0) begin
        check("R10 unexpected done", 1'b0, done_addr, 64'd0);
      end else begin
        exp_t  e;
        string t;
        e = expq.pop_front();
        t = tagq.pop_front();
        check(t, {done_addr, done_fault, flt_word6, flt_word7} == e,
              {done_addr[61:0], done_fault}, {e.addr[61:0], e.fault});
      end
    end
  end

  task automatic lookup(input string tag, input logic [15:0] sid, input logic [63:0] base,
                        input logic [31:0] cfg, input logic rsp_err,
                        input logic [63:0] rsp_data, input logic poke);
    int l2s, sp, lim, sh, t, l2;
    logic two, oor, fetch;
    logic [63:0] b, l1a;
    exp_t e;
    l2s = int'(cfg[5:0]);
    sp  = int'(cfg[10:6]);
    two = (cfg[17:16] == 2'd1);
    lim = (l2s < 16) ? l2s : 16;
    oor = (lim < 16) && (int'(sid) >= (1 << lim));
    e = '0;
    fetch = 1'b0;
    l1a = '0;
    if (oor) begin
      e.fault = 2'd1;
    end else if (!two) begin
      b = keep_above(base & KEEP, l2s + 5);
      e.addr = b + 64'(sid) * 64;
    end else begin
      t  = l2s - sp + 2;
      sh = (t < 5) ? 5 : t;
      b  = keep_above(base & KEEP, sh);
      l1a = b + 64'(int'(sid) >> sp) * 8;
      l2 = int'(sid) & ((1 << sp) - 1);
      fetch = 1'b1;
      if (rsp_err) begin
        e.fault = 2'd3;
        e.w6 = l1a[31:0];
        e.w7 = l1a[63:32];
      end else if (rsp_data[4:0] == 5'd0 || l2 >= (1 << (int'(rsp_data[4:0]) - 1))) begin
        e.fault = 2'd2;
      end else begin
        e.addr = (rsp_data & KEEP) + 64'(l2) * 64;
      end
    end
    expq.push_back(e);
    tagq.push_back(tag);
    @(negedge clk);
    req_valid = 1'b1; req_sid = sid; tbl_base = base; tbl_cfg = cfg;
    @(negedge clk);
    req_valid = 1'b0;
    if (fetch) begin
      check({tag, " R6 L1 request"}, mem_req_valid && mem_req_addr == l1a, mem_req_addr, l1a);
      if (poke) begin
        req_valid = 1'b1; req_sid = ~sid;
        @(negedge clk);
        check("R10 ready low while busy", req_ready == 1'b0, 64'(req_ready), 64'd0);
        check("R6 request is single cycle", mem_req_valid == 1'b0, 64'(mem_req_valid), 64'd0);
        req_valid = 1'b0;
        @(negedge clk);
      end
      mem_rsp_valid = 1'b1; mem_rsp_err = rsp_err; mem_rsp_data = rsp_data;
      @(negedge clk);
      mem_rsp_valid = 1'b0; mem_rsp_err = 1'b0;
    end else begin
      check({tag, " R2 no memory request"}, mem_req_valid == 1'b0, 64'(mem_req_valid), 64'd0);
    end
    @(negedge clk);
  endtask

  function automatic logic [31:0] mk_cfg(input int l2s, input int sp, input int fmt);
    return (32'(fmt) << 16) | (32'(sp) << 6) | 32'(l2s);
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1
    check("R1 done low", done == 1'b0, 64'(done), 64'd0);
    check("R1 mem_req low", mem_req_valid == 1'b0, 64'(mem_req_valid), 64'd0);
    check("R1 ready high", req_ready == 1'b1, 64'(req_ready), 64'd1);
    rst_n = 1'b1;
    @(negedge clk);
    // R3 R4: full-ones base, linear
    lookup("R3 R4 linear", 16'd5, 64'hFFFF_FFFF_FFFF_FFFF, mk_cfg(8, 0, 0), 1'b0, '0, 1'b0);
    lookup("R4 linear top sid", 16'd255, 64'h0123_4567_89AB_CDEF, mk_cfg(8, 0, 0), 1'b0, '0, 1'b0);
    lookup("R2 just over limit", 16'd256, 64'h0123_4567_89AB_CDEF, mk_cfg(8, 0, 0), 1'b0, '0, 1'b0);
    lookup("R2 impl limit wins", 16'hFFFF, 64'hFFFF_FFFF_FFFF_FFFF, mk_cfg(20, 0, 0), 1'b0, '0, 1'b0);
    lookup("R2 zero size", 16'd0, 64'h1000, mk_cfg(0, 0, 0), 1'b0, '0, 1'b0);
    lookup("R2 zero size sid1", 16'd1, 64'h1000, mk_cfg(0, 0, 0), 1'b0, '0, 1'b0);
    lookup("R11 format 2 linear", 16'd7, 64'hFFFF_FFFF_FFFF_FFFF, mk_cfg(4, 2, 2), 1'b0, '0, 1'b0);
    // R5 R7: two-level, alignment 10
    lookup("R5 R7 two-level", 16'h1234, 64'hFFFF_FFFF_FFFF_FFFF, mk_cfg(16, 8, 1), 1'b0,
           64'hFFF0_00AB_CDEF_0009, 1'b0);
    lookup("R5 R7 split6", 16'h03C5, 64'h0ABC_DEF0_1234_5678, mk_cfg(10, 6, 1), 1'b0,
           64'h0000_0012_3456_7FC7, 1'b0);
    lookup("R5 min alignment", 16'd13, 64'hFFFF_FFFF_FFFF_FFFF, mk_cfg(4, 2, 1), 1'b0,
           64'h0000_0000_0000_4003, 1'b0);
    lookup("R8 span zero", 16'h0101, 64'h8000, mk_cfg(16, 8, 1), 1'b0, 64'h0000_0000_0004_0000, 1'b0);
    lookup("R8 l2 over span", 16'd5, 64'h8000, mk_cfg(8, 4, 1), 1'b0, 64'h0000_0000_0004_0003, 1'b0);
    lookup("R7 l2 at span edge", 16'd3, 64'h8000, mk_cfg(8, 4, 1), 1'b0, 64'h0000_0000_0004_0003, 1'b0);
    lookup("R9 fetch fault", 16'h00F3, 64'h0009_8765_4321_0000, mk_cfg(12, 4, 1), 1'b1, '0, 1'b0);
    lookup("R2 two-level out of range", 16'h0400, 64'h8000, mk_cfg(10, 4, 1), 1'b0, '0, 1'b0);
    lookup("R10 busy request ignored", 16'h0042, 64'h0000_0001_0000_0000, mk_cfg(8, 4, 1), 1'b0,
           64'h0000_0000_0020_0005, 1'b1);
    repeat (3) @(negedge clk);
    check("R10 all results seen", expq.size() == 0, 64'(expq.size()), 64'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule